// File: doc/BRIEF.md
# Reloadable Interval Timer with Square-Wave Pin

This block is a down-counting interval timer driven from a byte-wide register port. Software programs a reload latch one byte at a time. Writing the counter-high address copies the latch into the counter and starts a countdown. When the count passes through zero, the timer raises a sticky flag for an interrupt controller and emits a one-clock timeout pulse. It also drives a square-wave output bit that a port B read can pick up in place of its bit 7.

The timer has two modes, chosen by a plain control pin. In single-shot mode it fires once per load, and the counter then wraps and keeps counting down without reloading. In repeating mode the counter reloads from the latch once it has shown zero and then all ones. This gives a timeout period of N+2 clocks, where N is the latch value.

The register port has no back-pressure. A write strobe is accepted on the clock edge where it is sampled, and read data is a combinational view of the addressed byte. The read strobe exists only to mark the side effect of a read. The mode, pin-enable and port-B pins are plain level signals with no handshake.

Top module: `ival_timer`

## Requirements
- R1: A write to address 0 (counter low) or address 2 (latch low) changes only the latch low byte. The counter keeps decrementing unchanged.
- R2: A write to address 1 (counter high) does four things on the same edge: it stores the byte as the latch high byte, loads the counter with {byte, latch low}, clears the flag and drives pb7 low.
- R3: A write to address 3 (latch high) stores the latch high byte and clears the flag. It does not reload the counter.
- R4: The counter decreases by one on every clock, wrapping from 0 to 0xFFFF. After a load of N, `timeout` is high for exactly one clock, starting N+1 clocks after the load edge, which is the clock after the counter shows 0.
- R5: With `freerun` low, a load produces exactly one timeout. The counter then runs on from 0xFFFF downward and produces no further timeouts.
- R6: With `freerun` high, the clock after the counter shows 0xFFFF it reloads from the latch. Timeouts therefore recur every N+2 clocks.
- R7: In single-shot mode pb7 goes high at the timeout and stays high. In repeating mode pb7 inverts at every timeout.
- R8: `flag` is set by a timeout and held until cleared. A read strobe at address 0 clears it, and a read at address 1 leaves it set. A timeout on the same edge as a clear leaves the flag set.
- R9: `rd_data` shows the counter low byte at address 0, the counter high byte at address 1, the latch low byte at address 2 and the latch high byte at address 3.
- R10: `portb_rd` equals `portb_pins` when `pb7_en` is low. When `pb7_en` is high, bit 7 is replaced by pb7.
- R11: During reset the counter and latch are 0, `flag` and `timeout` are low, and pb7 is high. No timeout occurs before the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register address: 0 cnt lo, 1 cnt hi, 2 latch lo, 3 latch hi |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Addressed byte |
| freerun | input | 1 | 1 = repeating mode, 0 = single-shot |
| pb7_en | input | 1 | Substitute pb7 into port B bit 7 |
| portb_pins | input | 8 | Raw port B input pins |
| portb_rd | output | 8 | Port B read value |
| timeout | output | 1 | One-clock timeout pulse |
| flag | output | 1 | Sticky timer flag |
| pb7 | output | 1 | Square-wave output bit |

## Verification
The hardest situation to reach from the ports is the repeating-mode cycle through 0, then 0xFFFF, then the reload. Its exact period and the pb7 toggles depend on counting every clock from the load edge. The bench therefore loads a small latch value, steps one clock at a time, and keeps its own model of the next count, the expected pulse and the expected pb7 level. It also reaches the one-shot wrap past zero and confirms over a long idle window that no second pulse appears.

// File: rtl/ival_pkg.sv
package ival_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_LAT_LO = 2'd2,
    REG_LAT_HI = 2'd3
  } ival_reg_e;
endpackage

// File: rtl/ival_latch.sv
module ival_latch #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] lat_lo,
  output logic [BYTE_W-1:0] lat_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_lo <= '0;
      lat_hi <= '0;
    end else begin
      if (lo_we) lat_lo <= din;
      if (hi_we) lat_hi <= din;
    end
  end

  p_lo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_we |=> lat_lo == $past(lat_lo));
endmodule

// File: rtl/ival_counter.sv
module ival_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             freerun,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic armed;

  // A load on the same edge pre-empts the expiry of the old count.
  assign expire = armed && (cnt == '0) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire;
      if (load) begin
        cnt   <= load_val;
        armed <= 1'b1;
      end else begin
        if (freerun && cnt == ALL_ONES) cnt <= reload_val;
        else                            cnt <= cnt - ONE;
        if (expire && !freerun) armed <= 1'b0;
      end
    end
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(freerun && cnt == ALL_ONES)) |=> cnt == $past(cnt) - ONE);
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && freerun && cnt == ALL_ONES) |=> cnt == $past(reload_val));
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !freerun) |=> !armed);
endmodule

// File: rtl/ival_wave.sv
module ival_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hi_latch_wr,
  input  logic rd_lo,
  input  logic expire,
  input  logic freerun,
  output logic flag,
  output logic pb7
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pb7  <= 1'b1;
    end else begin
      // set beats clear
      if (expire)                            flag <= 1'b1;
      else if (load || hi_latch_wr || rd_lo) flag <= 1'b0;

      if (load)        pb7 <= 1'b0;
      else if (expire) pb7 <= freerun ? ~pb7 : 1'b1;
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !load && !hi_latch_wr && !rd_lo) |=> $stable(flag));
  p_pb7_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !freerun) |=> pb7);
  p_pb7_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && freerun) |=> pb7 != $past(pb7));
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              freerun,
  input  logic              pb7_en,
  input  logic [BYTE_W-1:0] portb_pins,
  output logic [BYTE_W-1:0] portb_rd,
  output logic              timeout,
  output logic              flag,
  output logic              pb7
);
  localparam int unsigned HALF = CNT_W / 2;

  ival_reg_e reg_sel;
  logic [BYTE_W-1:0] lat_lo, lat_hi;
  logic [CNT_W-1:0]  cnt;
  logic              lo_we, hi_we, load, hi_latch_wr, rd_lo, expire;

  assign reg_sel     = ival_reg_e'(addr);
  assign lo_we       = wr_en && (reg_sel == REG_CNT_LO || reg_sel == REG_LAT_LO);
  assign load        = wr_en && (reg_sel == REG_CNT_HI);
  assign hi_latch_wr = wr_en && (reg_sel == REG_LAT_HI);
  assign hi_we       = load || hi_latch_wr;
  assign rd_lo       = rd_en && (reg_sel == REG_CNT_LO);

  ival_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
    .din(wr_data), .lat_lo(lat_lo), .lat_hi(lat_hi)
  );

  ival_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_val({wr_data, lat_lo}), .reload_val({lat_hi, lat_lo}),
    .freerun(freerun), .cnt(cnt), .expire(expire), .timeout(timeout)
  );

  ival_wave u_wave (
    .clk(clk), .rst_n(rst_n), .load(load), .hi_latch_wr(hi_latch_wr),
    .rd_lo(rd_lo), .expire(expire), .freerun(freerun),
    .flag(flag), .pb7(pb7)
  );

  always_comb begin
    unique case (reg_sel)
      REG_CNT_LO: rd_data = cnt[HALF-1:0];
      REG_CNT_HI: rd_data = cnt[CNT_W-1:HALF];
      REG_LAT_LO: rd_data = lat_lo;
      default:    rd_data = lat_hi;
    endcase
  end

  assign portb_rd = pb7_en ? {pb7, portb_pins[BYTE_W-2:0]} : portb_pins;

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == {$past(wr_data), $past(lat_lo)}) && !pb7);
  p_flag_with_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> flag);
  p_hi_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_latch_wr |=> lat_hi == $past(wr_data));
endmodule

// File: tb/test_ival_timer.sv
`timescale 1ns/1ps
module test_ival_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       freerun = 1'b0, pb7_en = 1'b0;
  logic [7:0] portb_pins = 8'd0;
  logic [7:0] portb_rd;
  logic       timeout, flag, pb7;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ival_timer i_ival_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .freerun(freerun), .pb7_en(pb7_en),
    .portb_pins(portb_pins), .portb_rd(portb_rd), .timeout(timeout),
    .flag(flag), .pb7(pb7)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #0.3; d = rd_data;
  endtask

  task automatic get_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    peek(2'd0, lo); peek(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic rd_strobe(input logic [1:0] a);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] c;
    logic [7:0] b;
    get_cnt(c);
    check("R11 cnt", c, 0);
    peek(2'd2, b); check("R11 latch lo", b, 0);
    check("R11 flag", flag, 0);
    check("R11 pb7", pb7, 1);
    check("R11 timeout", timeout, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tick();
      check("R11 no timeout before load", timeout, 0);
    end
  endtask

  task automatic t_oneshot();
    logic [15:0] c;
    logic [7:0] b;
    int pulses;
    freerun = 1'b0;
    wr(2'd2, 8'd5);
    wr(2'd1, 8'd0);
    get_cnt(c);
    check("R2 load", c, 16'd5);
    check("R2 flag", flag, 0);
    check("R2 pb7 low", pb7, 0);
    pb7_en = 1'b1; portb_pins = 8'hFF; #0.3;
    check("R10 pb7 sub low", portb_rd, 8'h7F);
    pb7_en = 1'b0; #0.3;
    check("R10 raw", portb_rd, 8'hFF);
    for (int k = 1; k <= 5; k++) begin
      tick();
      get_cnt(c);
      check("R4 countdown", c, 16'(5 - k));
      check("R4 no early pulse", timeout, 0);
    end
    tick();
    check("R4 pulse at N+1", timeout, 1);
    check("R8 flag set", flag, 1);
    check("R7 pb7 high", pb7, 1);
    get_cnt(c); check("R5 wrap", c, 16'hFFFF);
    tick();
    check("R4 pulse one wide", timeout, 0);
    get_cnt(c); check("R5 keeps counting", c, 16'hFFFE);
    pulses = 0;
    for (int k = 0; k < 60; k++) begin
      tick();
      if (timeout) pulses++;
    end
    check("R5 single pulse", pulses, 0);
    check("R7 pb7 stays", pb7, 1);
    rd_strobe(2'd1);
    check("R8 hi read keeps flag", flag, 1);
    rd_strobe(2'd0);
    check("R8 lo read clears", flag, 0);
  endtask

  task automatic t_low_writes();
    logic [15:0] c0, c1;
    logic [7:0] b;
    get_cnt(c0);
    wr(2'd0, 8'h77);
    get_cnt(c1);
    check("R1 cnt lo write no load", c1, c0 - 16'd1);
    peek(2'd2, b); check("R1 latch lo", b, 8'h77);
    get_cnt(c0);
    wr(2'd2, 8'h02);
    get_cnt(c1);
    check("R1 latch lo write no load", c1, c0 - 16'd1);
    peek(2'd2, b); check("R9 latch lo read", b, 8'h02);
  endtask

  task automatic t_latch_hi();
    logic [15:0] c0, c1;
    logic [7:0] b;
    wr(2'd1, 8'd0);
    for (int k = 0; k < 3; k++) tick();
    check("R3 setup flag", flag, 1);
    get_cnt(c0);
    wr(2'd3, 8'h12);
    get_cnt(c1);
    check("R3 flag cleared", flag, 0);
    check("R3 no reload", c1, c0 - 16'd1);
    peek(2'd3, b); check("R9 latch hi read", b, 8'h12);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_freerun();
    logic [15:0] c, model;
    logic exp_pb7;
    int since;
    freerun = 1'b1;
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd0);
    model = 16'd3; exp_pb7 = 1'b0;
    check("R2 freerun load pb7", pb7, 0);
    for (int k = 1; k <= 16; k++) begin
      logic exp_pulse;
      exp_pulse = (model == 16'd0);
      model = (model == 16'hFFFF) ? 16'd3 : model - 16'd1;
      if (exp_pulse) exp_pb7 = ~exp_pb7;
      tick();
      get_cnt(c);
      check("R6 freerun count", c, model);
      check("R6 freerun pulse", timeout, exp_pulse);
      check("R7 freerun pb7", pb7, exp_pb7);
    end
    pb7_en = 1'b1; portb_pins = 8'h5A; #0.3;
    check("R10 pb7 sub", portb_rd, {pb7, 7'h5A});
    pb7_en = 1'b0;
    since = 0;
    while (!timeout && since < 20) begin tick(); since++; end
    since = 0;
    tick();
    while (!timeout && since < 20) begin tick(); since++; end
    check("R6 period N+2", since + 1, 5);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #5;
    t_reset();
    t_oneshot();
    t_low_writes();
    t_latch_hi();
    t_freerun();
    done = 1'b1;
    finish_up();
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule